// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Receiver

This block takes a three-wire stereo PCM link (bit clock, word clock, serial data) and turns it into parallel left and right samples. All three wires are resynchronised into the master-clock domain, and the bit clock is used only through its detected rising edges. Because of this the bit clock may stop between bursts of pulses. A static format input picks one of three framings: left-justified, I2S, or right-justified. A length input picks a 16-, 18- or 20-bit word. Both inputs are captured while reset is held.

Each channel word arrives MSB first in two's complement, and the left field always comes before the right field. The word is sign-extended to 20 bits. Once the right word of a frame has been closed, both words are presented together with a one-cycle strobe.

For a fixed number of master-clock cycles after reset, field boundaries follow the word clock, and the block learns how many bit-clock edges make up a field. When that window closes, an internal sequencer takes over. It counts bit-clock edges modulo the learned field length and alternates channels by itself, so the word clock's phase is held from then on until the next reset.

Top module: `stereo_serial_rx`

## Requirements
- R1: Serial data and word clock are taken only on bit-clock rising edges. Idle gaps of any length with the bit clock low change nothing.
- R2: Format code 0 (and the unused code 3) selects left-justified framing. The word clock is high for left and low for right, and the MSB is the bit taken on the first rising edge after a word-clock change (edge index 0).
- R3: Format code 1 selects I2S framing. The word clock is low for left and high for right, and the MSB is at edge index 1 of the field.
- R4: Format code 2 selects right-justified framing. The word clock is high for left, the MSB is at edge index 16, and the word is always 16 bits whatever the length input says.
- R5: Length code 0 gives 16 bits, code 1 gives 18 bits, and codes 2 and 3 give 20 bits. Each word is output as a 20-bit two's-complement value, sign-extended from its MSB.
- R6: Bits in a field that fall before the MSB index or after the last bit of the selected length have no effect on the output word.
- R7: If a field ends before all word bits have arrived, the missing low-order bits are taken as zero.
- R8: A field is closed on the first rising edge of the next field. When a right field closes after a left field of the same frame, `smp_left` and `smp_right` update together and `smp_valid` is high for exactly one cycle. The outputs change at no other time.
- R9: `cfg_fmt` and `cfg_len` are captured only while `rst` is high. Changing them afterwards has no effect until the next reset.
- R10: Once LOCK_CYCLES master cycles have passed since reset and one full field length has been measured, field boundaries come from counting bit-clock edges. From then on the word clock is ignored, so frames still decode correctly with the word clock held constant.
- R11: During and right after reset, `smp_valid` is low and both sample outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset; also captures configuration |
| cfg_fmt | input | 2 | Framing select: 0 left-justified, 1 I2S, 2 right-justified, 3 as 0 |
| cfg_len | input | 2 | Word length select: 0 = 16, 1 = 18, 2/3 = 20 bits |
| ser_bclk | input | 1 | Serial bit clock, asynchronous, may be gated |
| ser_wclk | input | 1 | Left/right word clock, asynchronous |
| ser_data | input | 1 | Serial data, MSB first |
| smp_left | output | 20 | Sign-extended left sample |
| smp_right | output | 20 | Sign-extended right sample |
| smp_valid | output | 1 | One-cycle strobe for a new stereo pair |

## Verification
A frame's samples are not due until the first bit-clock rising edge of the following field. After that edge comes a fixed delay of a few master cycles: two synchroniser stages, one edge-detect stage, the word-assembly register and the output register. The delay is only a few cycles, while a bit period in the bench lasts eight or more master cycles. So the bench does not sample at a fixed cycle. A monitor records every strobe on the falling edge of the master clock, and after each burst the bench ends with one trailing bit so that the last frame is closed. It then waits a fixed margin before comparing the recorded pairs and the strobe count with values its own functions compute from each field's length, format and word length.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int SAMPLE_W  = 20;
    localparam int CNT_W     = 8;
    localparam int LEN_W     = 5;
    localparam int RJ_OFFSET = 16;
    localparam int RJ_LEN    = 16;

    typedef enum logic [1:0] {
        FMT_LJ  = 2'd0,
        FMT_I2S = 2'd1,
        FMT_RJ  = 2'd2
    } fmt_e;

    typedef struct packed {
        logic             bit_en;
        logic             field_start;
        logic             finish;
        logic             fin_left;
        logic [CNT_W-1:0] k;
    } evt_t;

    function automatic fmt_e decode_fmt(input logic [1:0] code);
        case (code)
            2'd1:    return FMT_I2S;
            2'd2:    return FMT_RJ;
            default: return FMT_LJ;
        endcase
    endfunction

    function automatic logic [LEN_W-1:0] word_len(input fmt_e fmt, input logic [1:0] code);
        if (fmt == FMT_RJ) return LEN_W'(RJ_LEN);
        case (code)
            2'd0:    return LEN_W'(16);
            2'd1:    return LEN_W'(18);
            default: return LEN_W'(20);
        endcase
    endfunction

    function automatic int msb_offset(input fmt_e fmt);
        case (fmt)
            FMT_I2S: return 1;
            FMT_RJ:  return RJ_OFFSET;
            default: return 0;
        endcase
    endfunction

    function automatic logic left_level(input fmt_e fmt);
        return (fmt == FMT_I2S) ? 1'b0 : 1'b1;
    endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync,
    output logic             rise0
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        if (g == 0) begin : g_edge
            logic [STAGES:0] pipe;
            always_ff @(posedge clk) begin
                if (rst) pipe <= '0;
                else     pipe <= {pipe[STAGES-1:0], d_async[g]};
            end
            assign d_sync[g] = pipe[STAGES-1];
            assign rise0     = pipe[STAGES-1] & ~pipe[STAGES];
        end else begin : g_plain
            logic [STAGES-1:0] pipe;
            always_ff @(posedge clk) begin
                if (rst) pipe <= '0;
                else     pipe <= {pipe[STAGES-2:0], d_async[g]};
            end
            assign d_sync[g] = pipe[STAGES-1];
        end
    end

endmodule

// File: rtl/srx_seq.sv
module srx_seq
    import srx_pkg::*;
#(
    parameter int LOCK_CYCLES = 30000
) (
    input  logic clk,
    input  logic rst,
    input  logic rise,
    input  logic wclk,
    input  fmt_e fmt,
    output evt_t evt,
    output logic locked
);

    localparam int LCW = $clog2(LOCK_CYCLES + 1);

    logic             primed, w_prev, started, cur_left, fl_known, win_done;
    logic [CNT_W-1:0] k, fl, k_inc;
    logic [LCW-1:0]   lock_cnt;
    logic             boundary, new_left;

    assign locked = win_done & fl_known;

    always_comb begin
        k_inc = (k == {CNT_W{1'b1}}) ? k : k + 1'b1;
        if (locked) begin
            boundary = (k == fl - 1'b1);
            new_left = ~cur_left;
        end else begin
            boundary = primed && (wclk != w_prev);
            new_left = (wclk == left_level(fmt));
        end
        evt.field_start = rise && boundary;
        evt.finish      = rise && boundary && started;
        evt.fin_left    = cur_left;
        evt.bit_en      = rise && (started || boundary);
        evt.k           = boundary ? '0 : k_inc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            primed   <= 1'b0;
            w_prev   <= 1'b0;
            started  <= 1'b0;
            cur_left <= 1'b0;
            fl_known <= 1'b0;
            k        <= '0;
            fl       <= '0;
        end else if (rise) begin
            primed <= 1'b1;
            w_prev <= wclk;
            if (boundary) begin
                started  <= 1'b1;
                cur_left <= new_left;
                k        <= '0;
                if (!locked && started) begin
                    fl       <= k + 1'b1;
                    fl_known <= 1'b1;
                end
            end else begin
                k <= k_inc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_cnt <= '0;
            win_done <= 1'b0;
        end else if (!win_done) begin
            lock_cnt <= lock_cnt + 1'b1;
            if (lock_cnt == LCW'(LOCK_CYCLES - 1)) win_done <= 1'b1;
        end
    end

    // R10: once the counted sequencer owns the framing it keeps it until reset
    p_lock_hold_r10: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);

    // R10: in locked operation a field wraps after the learned edge count
    p_count_wrap_r10: assert property (@(posedge clk) disable iff (rst)
        (locked && rise && (k == fl - 1'b1)) |=> (k == '0));

    // R1: the edge index only moves on a detected bit-clock rise
    p_idx_on_edge_r1: assert property (@(posedge clk) disable iff (rst)
        !rise |=> $stable(k));

endmodule

// File: rtl/srx_word_asm.sv
module srx_word_asm
    import srx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  evt_t                evt,
    input  logic                data,
    input  fmt_e                fmt,
    input  logic [LEN_W-1:0]    wlen,
    output logic                done,
    output logic                done_left,
    output logic [SAMPLE_W-1:0] done_word
);

    logic [SAMPLE_W-1:0] acc, acc_next;
    int                  rel;

    always_comb begin
        acc_next = evt.field_start ? '0 : acc;
        rel      = int'(evt.k) - msb_offset(fmt);
        for (int i = 0; i < SAMPLE_W; i++) begin
            if (evt.bit_en && rel == i && i < int'(wlen))
                acc_next[SAMPLE_W-1-i] = data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc       <= '0;
            done      <= 1'b0;
            done_left <= 1'b0;
            done_word <= '0;
        end else begin
            acc  <= acc_next;
            done <= evt.finish;
            if (evt.finish) begin
                done_left <= evt.fin_left;
                done_word <= SAMPLE_W'($signed(acc) >>> (SAMPLE_W - int'(wlen)));
            end
        end
    end

    // R8: a closed field produces a single completion pulse
    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/stereo_serial_rx.sv
module stereo_serial_rx
    import srx_pkg::*;
#(
    parameter int LOCK_CYCLES = 30000,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          cfg_fmt,
    input  logic [1:0]          cfg_len,
    input  logic                ser_bclk,
    input  logic                ser_wclk,
    input  logic                ser_data,
    output logic [SAMPLE_W-1:0] smp_left,
    output logic [SAMPLE_W-1:0] smp_right,
    output logic                smp_valid
);

    fmt_e                fmt_q;
    logic [LEN_W-1:0]    wlen_q;
    logic [2:0]          pins_s;
    logic                bclk_rise;
    evt_t                evt;
    logic                seq_locked;
    logic                w_done, w_left;
    logic [SAMPLE_W-1:0] w_word, left_hold;
    logic                have_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            fmt_q  <= decode_fmt(cfg_fmt);
            wlen_q <= word_len(decode_fmt(cfg_fmt), cfg_len);
        end
    end

    srx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async ({ser_data, ser_wclk, ser_bclk}),
        .d_sync  (pins_s),
        .rise0   (bclk_rise)
    );

    srx_seq #(.LOCK_CYCLES(LOCK_CYCLES)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .rise   (bclk_rise),
        .wclk   (pins_s[1]),
        .fmt    (fmt_q),
        .evt    (evt),
        .locked (seq_locked)
    );

    srx_word_asm u_asm (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .data      (pins_s[2]),
        .fmt       (fmt_q),
        .wlen      (wlen_q),
        .done      (w_done),
        .done_left (w_left),
        .done_word (w_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            left_hold <= '0;
            have_left <= 1'b0;
            smp_left  <= '0;
            smp_right <= '0;
            smp_valid <= 1'b0;
        end else begin
            smp_valid <= 1'b0;
            if (w_done) begin
                if (w_left) begin
                    left_hold <= w_word;
                    have_left <= 1'b1;
                end else begin
                    have_left <= 1'b0;
                    if (have_left) begin
                        smp_left  <= left_hold;
                        smp_right <= w_word;
                        smp_valid <= 1'b1;
                    end
                end
            end
        end
    end

    // R8: strobe lasts one cycle
    p_valid_single_r8: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> !smp_valid);

    // R8: samples only move together with the strobe
    p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!$stable(smp_left) || !$stable(smp_right)) |-> smp_valid);

    // R9: configuration stays fixed outside reset
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ($stable(fmt_q) && $stable(wlen_q)));

    // R11: reset clears the outputs
    p_reset_zero_r11: assert property (@(posedge clk)
        rst |=> (!smp_valid && smp_left == '0 && smp_right == '0));

    // R4: right-justified framing never uses a word other than 16 bits
    p_rj_len_r4: assert property (@(posedge clk) disable iff (rst)
        (fmt_q == FMT_RJ) |-> (wlen_q == LEN_W'(RJ_LEN)));

endmodule

// File: tb/stereo_serial_rx_bench.sv
module stereo_serial_rx_bench;

    localparam int LOCKN = 4000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_fmt = 2'd0;
    logic [1:0]  cfg_len = 2'd0;
    logic        ser_bclk = 1'b0;
    logic        ser_wclk = 1'b0;
    logic        ser_data = 1'b0;
    logic [19:0] smp_left, smp_right;
    logic        smp_valid;

    int checks = 0;
    int fails  = 0;
    int npulse = 0;
    int wd     = 0;
    int cyc_rst = 0;
    bit finished = 0;
    bit gaps = 0;
    logic prev_valid = 1'b0;
    logic [19:0] got_l [0:63];
    logic [19:0] got_r [0:63];
    logic [19:0] exp_l [0:63];
    logic [19:0] exp_r [0:63];

    always #2 clk = ~clk;

    stereo_serial_rx #(.LOCK_CYCLES(LOCKN)) u_stereo_serial_rx (
        .clk(clk), .rst(rst), .cfg_fmt(cfg_fmt), .cfg_len(cfg_len),
        .ser_bclk(ser_bclk), .ser_wclk(ser_wclk), .ser_data(ser_data),
        .smp_left(smp_left), .smp_right(smp_right), .smp_valid(smp_valid)
    );

    task automatic check(input bit ok, input string req, input logic [19:0] act, input logic [19:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // monitor: record strobes, R8 single-cycle width
    always @(negedge clk) begin
        if (rst) cyc_rst <= 0; else cyc_rst <= cyc_rst + 1;
        if (smp_valid && !rst) begin
            check(!prev_valid, "R8 strobe width", 20'(prev_valid), 20'd0);
            if (npulse < 64) begin
                got_l[npulse] = smp_left;
                got_r[npulse] = smp_right;
            end
            npulse++;
        end
        prev_valid <= smp_valid;
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 190000 && !finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<190000", wd);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    function automatic int off_of(input int m);
        return (m == 1) ? 1 : (m == 2) ? 16 : 0;
    endfunction

    function automatic int wl_of(input int m, input int l);
        if (m == 2) return 16;
        return (l == 0) ? 16 : (l == 1) ? 18 : 20;
    endfunction

    function automatic logic [19:0] exp_word(input logic [19:0] val, input int wl, input int off, input int fb);
        logic [19:0] acc = '0;
        for (int i = 0; i < wl; i++)
            if (off + i < fb) acc[19-i] = val[wl-1-i];
        return 20'($signed(acc) >>> (20 - wl));
    endfunction

    task automatic bit_out(input logic w, input logic d);
        @(negedge clk);
        ser_bclk = 1'b0;
        ser_wclk = w;
        ser_data = d;
        repeat (gaps ? 3 + ($urandom % 8) : 3) @(negedge clk);
        ser_bclk = 1'b1;
        repeat (4) @(negedge clk);
        ser_bclk = 1'b0;
    endtask

    task automatic field(input logic w, input logic [19:0] val, input int wl, input int off, input int fb);
        for (int k = 0; k < fb; k++) begin
            int p;
            p = k - off;
            if (p >= 0 && p < wl) bit_out(w, val[wl-1-p]);
            else                  bit_out(w, 1'($urandom));
        end
    endtask

    task automatic do_reset(input int m, input int l);
        @(negedge clk);
        rst = 1'b1;
        cfg_fmt = 2'(m);
        cfg_len = 2'(l);
        ser_bclk = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
    endtask

    // send nfr frames; whold >= 0 holds the word clock at that level (locked use)
    task automatic frames(input int m, input int l, input int fb, input int nfr, input int whold, input int base);
        logic lv;
        int wl, off;
        lv  = (m == 1) ? 1'b0 : 1'b1;
        wl  = wl_of(m, l);
        off = off_of(m);
        for (int f = 0; f < nfr; f++) begin
            logic [19:0] vl, vr;
            vl = 20'($urandom);
            vr = 20'($urandom);
            if (f == 0) vl = 20'hFFFFF;
            if (f == 1) vr = 20'h00000;
            exp_l[base+f] = exp_word(vl, wl, off, fb);
            exp_r[base+f] = exp_word(vr, wl, off, fb);
            field((whold >= 0) ? 1'(whold) : lv,  vl, wl, off, fb);
            field((whold >= 0) ? 1'(whold) : ~lv, vr, wl, off, fb);
        end
    endtask

    task automatic compare(input int base, input int nfr, input string req);
        repeat (16) @(negedge clk);
        check(npulse == base + nfr, {req, " R8 frame count"}, 20'(npulse), 20'(base + nfr));
        for (int f = 0; f < nfr; f++) begin
            if (base + f < npulse && base + f < 64) begin
                check(got_l[base+f] == exp_l[base+f], {req, " left"}, got_l[base+f], exp_l[base+f]);
                check(got_r[base+f] == exp_r[base+f], {req, " right"}, got_r[base+f], exp_r[base+f]);
            end
        end
    endtask

    task automatic run_test(input int m, input int l, input int fb, input int nfr, input bit chg, input string req);
        logic lv;
        int base;
        lv = (m == 1) ? 1'b0 : 1'b1;
        do_reset(m, l);
        if (chg) begin
            cfg_fmt = 2'((m + 1) % 3);
            cfg_len = 2'((l + 1) % 3);
        end
        for (int i = 0; i < 3; i++) bit_out(~lv, 1'b1);
        base = (npulse < 64) ? npulse : 0;
        if (npulse >= 64) npulse = 0;
        frames(m, l, fb, nfr, -1, base);
        bit_out(lv, 1'b0);
        compare(base, nfr, req);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset(0, 0);
        @(negedge clk);
        check(smp_valid == 1'b0 && smp_left == '0 && smp_right == '0, "R11 reset state", smp_left, 20'd0);

        // directed cases
        run_test(0, 2, 24, 3, 0, "R2 left-justified 20b");
        run_test(1, 0, 20, 3, 0, "R3 I2S 16b");
        run_test(1, 1, 19, 2, 0, "R3 I2S 18b at exact field");
        run_test(2, 2, 32, 3, 0, "R4 right-justified ignores length 20");
        run_test(0, 0, 32, 2, 0, "R6 extra bits ignored 16b");
        run_test(0, 2, 12, 2, 0, "R7 short field zero padded");
        run_test(2, 0, 24, 2, 0, "R7 right-justified short field");
        run_test(0, 3, 22, 2, 0, "R5 length code 3 as 20b");
        run_test(1, 2, 24, 2, 1, "R9 config change after reset ignored");
        gaps = 1;
        run_test(0, 1, 20, 3, 0, "R1 gated bit clock 18b");
        run_test(3, 0, 18, 2, 0, "R2 format code 3 as left-justified");

        // reset after traffic clears outputs
        do_reset(0, 0);
        @(negedge clk);
        check(smp_valid == 1'b0 && smp_left == '0 && smp_right == '0, "R11 reset after traffic", smp_right, 20'd0);

        // constrained random
        for (int t = 0; t < 6; t++) begin
            int m, l, fb;
            m  = $urandom % 3;
            l  = $urandom % 3;
            fb = (m == 2) ? 32 : 16 + ($urandom % 20);
            gaps = 1'($urandom);
            run_test(m, l, fb, 3, 0, "R5 random format/length");
        end
        gaps = 0;

        // R10: counted sequencer after the lock window, word clock held low
        begin
            int base;
            do_reset(0, 2);
            for (int i = 0; i < 3; i++) bit_out(1'b0, 1'b0);
            npulse = 0;
            base = 0;
            frames(0, 2, 24, 2, -1, 0);
            while (cyc_rst < LOCKN + 40) @(negedge clk);
            frames(0, 2, 24, 2, 0, 2);
            bit_out(1'b0, 1'b0);
            compare(base, 4, "R10 locked sequencer");
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule